// File: doc/BRIEF.md
# Sleep and Wake-Up Controller

This block governs the power-down state of a small 8-bit microcontroller core. The instruction decoder raises `sleep_req` when it executes a sleep instruction. The controller then gates the CPU clock, clears the watchdog and updates the power-down and timeout status flags. While the core sleeps, the controller tells the oscillator block which clocks must stay alive, and it watches a set of wake sources.

Wake sources fall into two classes. The reset class is the external reset pin, brown-out and power-on. A reset-class wake restarts the clock and raises a one-cycle reset request. The continuation class is a watchdog timeout (only when the watchdog runs during sleep) and any interrupt whose own enable bit is set. A continuation wake restarts the clock and raises a resume pulse. The global interrupt enable has no say in whether an interrupt wakes the core. It only decides what happens next: when it is set and an interrupt caused the wake, the controller waits until the already-prefetched instruction after the sleep retires (`post_sleep_done`), then requests a vector to the service routine.

The controller is a three-state machine. State ST_RUN goes to ST_SLEEP on an accepted sleep request. ST_SLEEP goes back to ST_RUN on a reset-class wake, a watchdog wake, or an interrupt wake with the global enable clear. ST_SLEEP goes to ST_VEC_WAIT on an interrupt wake with the global enable set. ST_VEC_WAIT goes to ST_RUN when the post-sleep instruction retires, or when a reset-class source appears.

Top module: `slp_wake_ctrl`

## Requirements
- R1: After `rst_n` is released, `cpu_clk_en`=1, `pd_flag`=1 and `to_flag`=1, and `wdt_clear`, `reset_req`, `resume` and `isr_vector_req` are all 0.
- R2: When `sleep_req` is high in ST_RUN and no reset-class source is active, then after the next clock edge `cpu_clk_en`=0, `wdt_clear` pulses for one cycle, `pd_flag`=0 and `to_flag`=1.
- R3: While asleep, `lf_osc_keep`=1, `wdt_run` equals `wdt_sleep_en`, and `hf_osc_keep`=1 exactly when `hf_sel_wavegen` or `hf_sel_nco` is high. While running, `hf_osc_keep`=0 and `wdt_run`=1.
- R4: An interrupt wakes the core only when some bit i has both `irq_flag[i]` and `irq_en[i]` set, whatever `irq_global_en` holds. One edge after the wake, `cpu_clk_en`=1 and `resume` and `wdt_clear` pulse.
- R5: A `wdt_expired` pulse during sleep causes a continuation wake and clears `to_flag`, but only when `wdt_sleep_en`=1. When `wdt_sleep_en`=0 it is ignored: the core stays asleep and `to_flag` stays 1.
- R6: `pin_rst`, `brownout_rst` or `poweron_rst` during sleep wakes the core with `reset_req`=1, `wdt_clear`=1 and `resume`=0.
- R7: When reset-class and continuation sources are active in the same sleep cycle, the reset class wins. `reset_req` pulses, while `resume` and `isr_vector_req` stay 0.
- R8: After an interrupt wake with `irq_global_en`=1, `isr_vector_req` pulses one edge after `post_sleep_done` is seen. After any other continuation wake, including a watchdog wake with `irq_global_en`=1, it stays 0.
- R9: In ST_RUN, a reset-class source or `wdt_expired` produces `reset_req` for exactly one cycle on its rising edge. A watchdog timeout while running also clears `to_flag`.
- R10: A `sleep_req` that arrives in the same cycle as a reset-class source is ignored, and `cpu_clk_en` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (always-on domain) |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Sleep instruction executed strobe |
| pin_rst | input | 1 | External reset pin request |
| brownout_rst | input | 1 | Brown-out reset request |
| poweron_rst | input | 1 | Power-on reset request |
| wdt_expired | input | 1 | Watchdog timeout |
| wdt_sleep_en | input | 1 | Watchdog configured to run during sleep |
| irq_flag | input | N_IRQ | Interrupt flags (bit 0 external, others peripherals) |
| irq_en | input | N_IRQ | Per-source interrupt enables |
| irq_global_en | input | 1 | Global interrupt enable |
| post_sleep_done | input | 1 | Instruction after sleep has retired |
| hf_sel_wavegen | input | 1 | Waveform generator clocked by high-frequency oscillator |
| hf_sel_nco | input | 1 | NCO clocked by high-frequency oscillator |
| cpu_clk_en | output | 1 | CPU clock enable |
| wdt_clear | output | 1 | Watchdog clear pulse |
| wdt_run | output | 1 | Watchdog count enable |
| pd_flag | output | 1 | Power-down status flag |
| to_flag | output | 1 | Timeout status flag |
| reset_req | output | 1 | Device reset request pulse |
| resume | output | 1 | Continuation wake pulse |
| isr_vector_req | output | 1 | Vector-to-service-routine request pulse |
| lf_osc_keep | output | 1 | Keep low-frequency oscillator on in sleep |
| hf_osc_keep | output | 1 | Keep high-frequency oscillator on in sleep |

## Verification
The state register and every pulse and flag are updated at the clock edge that samples the stimulus. So `cpu_clk_en`, `wdt_clear`, `resume`, `reset_req`, `isr_vector_req`, `pd_flag` and `to_flag` are due exactly one edge after the triggering input. `lf_osc_keep`, `hf_osc_keep` and `wdt_run` follow the state combinationally, so they are valid in the same cycle the state changes, and a change of oscillator select is seen at once. The bench changes inputs 1 ns after a rising edge and reads the outputs 1 ns after the following rising edge. Each check therefore sees exactly the edge it expects and never the one after it.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_SLEEP    = 2'd1,
        ST_VEC_WAIT = 2'd2
    } slp_state_e;

    // Classified wake/reset events for one cycle
    typedef struct packed {
        logic rst_class;  // pin / brown-out / power-on, or watchdog while running
        logic irq_wake;   // qualified interrupt while asleep
        logic wdt_wake;   // watchdog timeout while asleep with sleep-run enabled
        logic wdt_hit;    // a watchdog timeout that takes effect
    } wake_cls_t;

endpackage

// File: rtl/slp_wake_qual.sv
module slp_wake_qual
    import slp_pkg::*;
#(
    parameter int N_IRQ = 4
) (
    input  logic             asleep,
    input  logic             pin_rst,
    input  logic             brownout_rst,
    input  logic             poweron_rst,
    input  logic             wdt_expired,
    input  logic             wdt_sleep_en,
    input  logic [N_IRQ-1:0] irq_flag,
    input  logic [N_IRQ-1:0] irq_en,
    output wake_cls_t        cls
);

    localparam int LAST = N_IRQ - 1;

    logic [LAST:0] qual;
    logic          any_irq;
    logic          hw_rst;
    logic          wdt_live;

    // Per-source qualification: flag and its own enable, no global gate
    for (genvar i = 0; i < N_IRQ; i++) begin : g_qual
        assign qual[i] = irq_flag[i] & irq_en[i];
    end

    assign any_irq  = |qual;
    assign hw_rst   = pin_rst | brownout_rst | poweron_rst;
    assign wdt_live = wdt_expired & (~asleep | wdt_sleep_en);

    always_comb begin
        cls.rst_class = hw_rst | (wdt_expired & ~asleep);
        cls.irq_wake  = asleep & any_irq;
        cls.wdt_wake  = asleep & wdt_expired & wdt_sleep_en;
        cls.wdt_hit   = wdt_live;
    end

endmodule

// File: rtl/slp_osc_keep.sv
module slp_osc_keep (
    input  logic asleep,
    input  logic hf_sel_wavegen,
    input  logic hf_sel_nco,
    input  logic wdt_sleep_en,
    output logic lf_osc_keep,
    output logic hf_osc_keep,
    output logic wdt_run
);

    // Low-frequency domain stays alive in sleep for its peripherals
    assign lf_osc_keep = asleep;
    // High-frequency oscillator held only if a consumer selected it
    assign hf_osc_keep = asleep & (hf_sel_wavegen | hf_sel_nco);
    // Watchdog counts while running, and in sleep only if configured
    assign wdt_run     = ~asleep | wdt_sleep_en;

endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
    import slp_pkg::*;
#(
    parameter int N_IRQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             pin_rst,
    input  logic             brownout_rst,
    input  logic             poweron_rst,
    input  logic             wdt_expired,
    input  logic             wdt_sleep_en,
    input  logic [N_IRQ-1:0] irq_flag,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             irq_global_en,
    input  logic             post_sleep_done,
    input  logic             hf_sel_wavegen,
    input  logic             hf_sel_nco,
    output logic             cpu_clk_en,
    output logic             wdt_clear,
    output logic             wdt_run,
    output logic             pd_flag,
    output logic             to_flag,
    output logic             reset_req,
    output logic             resume,
    output logic             isr_vector_req,
    output logic             lf_osc_keep,
    output logic             hf_osc_keep
);

    slp_state_e state;
    slp_state_e state_nx;
    wake_cls_t  cls;
    logic       asleep;
    logic       go_sleep;
    logic       wake_rst;
    logic       wake_cont;
    logic       vec_fire;
    logic       rst_class_q;

    assign asleep = (state == ST_SLEEP);

    slp_wake_qual #(.N_IRQ(N_IRQ)) u_qual (
        .asleep       (asleep),
        .pin_rst      (pin_rst),
        .brownout_rst (brownout_rst),
        .poweron_rst  (poweron_rst),
        .wdt_expired  (wdt_expired),
        .wdt_sleep_en (wdt_sleep_en),
        .irq_flag     (irq_flag),
        .irq_en       (irq_en),
        .cls          (cls)
    );

    slp_osc_keep u_osc (
        .asleep         (asleep),
        .hf_sel_wavegen (hf_sel_wavegen),
        .hf_sel_nco     (hf_sel_nco),
        .wdt_sleep_en   (wdt_sleep_en),
        .lf_osc_keep    (lf_osc_keep),
        .hf_osc_keep    (hf_osc_keep),
        .wdt_run        (wdt_run)
    );

    // Transition events
    always_comb begin
        go_sleep  = (state == ST_RUN) & sleep_req & ~cls.rst_class;
        wake_rst  = asleep & cls.rst_class;
        wake_cont = asleep & ~cls.rst_class & (cls.irq_wake | cls.wdt_wake);
        vec_fire  = (state == ST_VEC_WAIT) & post_sleep_done & ~cls.rst_class;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (go_sleep) state_nx = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (wake_rst)
                    state_nx = ST_RUN;
                else if (wake_cont)
                    state_nx = (cls.irq_wake & irq_global_en) ? ST_VEC_WAIT : ST_RUN;
            end
            ST_VEC_WAIT: begin
                if (cls.rst_class | post_sleep_done) state_nx = ST_RUN;
            end
            default: state_nx = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    assign cpu_clk_en = ~asleep;

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdt_clear      <= 1'b0;
            resume         <= 1'b0;
            reset_req      <= 1'b0;
            isr_vector_req <= 1'b0;
            rst_class_q    <= 1'b0;
            pd_flag        <= 1'b1;
            to_flag        <= 1'b1;
        end else begin
            wdt_clear      <= go_sleep | wake_rst | wake_cont;
            resume         <= wake_cont;
            reset_req      <= cls.rst_class & ~rst_class_q;
            isr_vector_req <= vec_fire;
            rst_class_q    <= cls.rst_class;
            if (go_sleep) begin
                pd_flag <= 1'b0;
                to_flag <= 1'b1;
            end
            if (cls.wdt_hit) to_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/slp_wake_ctrl_chk.sv
module slp_wake_ctrl_chk
    import slp_pkg::*;
#(
    parameter int N_IRQ = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_req,
    input logic             pin_rst,
    input logic             brownout_rst,
    input logic             poweron_rst,
    input logic             wdt_expired,
    input logic             wdt_sleep_en,
    input logic [N_IRQ-1:0] irq_flag,
    input logic [N_IRQ-1:0] irq_en,
    input logic             post_sleep_done,
    input logic             hf_sel_wavegen,
    input logic             hf_sel_nco,
    input logic             cpu_clk_en,
    input logic             wdt_clear,
    input logic             wdt_run,
    input logic             pd_flag,
    input logic             to_flag,
    input logic             reset_req,
    input logic             resume,
    input logic             isr_vector_req,
    input logic             lf_osc_keep,
    input logic             hf_osc_keep,
    input slp_state_e       state
);

    logic hw_any;
    assign hw_any = pin_rst | brownout_rst | poweron_rst;

    assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_req && !hw_any && !wdt_expired)
        |=> (!cpu_clk_en && wdt_clear && !pd_flag && to_flag));

    assert_keep_alive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_clk_en |-> (lf_osc_keep && (wdt_run == wdt_sleep_en)
                         && (hf_osc_keep == (hf_sel_wavegen || hf_sel_nco))));

    assert_irq_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && (|(irq_flag & irq_en)) && !hw_any)
        |=> (cpu_clk_en && resume && wdt_clear));

    assert_reset_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && hw_any) |=> (cpu_clk_en && !resume && wdt_clear));

    assert_class_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reset_req && resume));

    assert_vector_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        isr_vector_req |-> $past(post_sleep_done));

    assert_reset_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    assert_sleep_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_req && hw_any) |=> cpu_clk_en);

endmodule

bind slp_wake_ctrl slp_wake_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (.*);

// File: tb/slp_wake_ctrl_test.sv
module slp_wake_ctrl_test;

    localparam int  N_IRQ = 4;
    localparam time CLK_P = 20ns;

    typedef struct packed {
        logic [2:0] rsrc;   // [2] pin, [1] brown-out, [0] power-on
        logic       wdt;
        logic       wse;
        logic [3:0] flg;
        logic [3:0] en;
        logic       gie;
        logic       e_awake;
        logic       e_res;
        logic       e_rst;
        logic       e_vec;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{3'b000, 1'b0, 1'b0, 4'b0001, 4'b0001, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R4 gie clear
        '{3'b000, 1'b0, 1'b0, 4'b0100, 4'b0100, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R4 R8 gie set
        '{3'b000, 1'b0, 1'b0, 4'b0010, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 disabled
        '{3'b000, 1'b0, 1'b0, 4'b0100, 4'b1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 mismatched bits
        '{3'b000, 1'b1, 1'b1, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 R8 wdt wake
        '{3'b000, 1'b1, 1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 ignored
        '{3'b100, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R6 pin
        '{3'b010, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R6 brown-out
        '{3'b001, 1'b0, 1'b0, 4'b1000, 4'b1000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 power-on + irq
        '{3'b100, 1'b1, 1'b1, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 pin + wdt
        '{3'b000, 1'b0, 1'b0, 4'b1000, 4'b1111, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}  // R4 top bit
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sleep_req = 1'b0;
    logic             pin_rst = 1'b0;
    logic             brownout_rst = 1'b0;
    logic             poweron_rst = 1'b0;
    logic             wdt_expired = 1'b0;
    logic             wdt_sleep_en = 1'b0;
    logic [N_IRQ-1:0] irq_flag = '0;
    logic [N_IRQ-1:0] irq_en = '0;
    logic             irq_global_en = 1'b0;
    logic             post_sleep_done = 1'b0;
    logic             hf_sel_wavegen = 1'b0;
    logic             hf_sel_nco = 1'b0;
    logic             cpu_clk_en, wdt_clear, wdt_run, pd_flag, to_flag;
    logic             reset_req, resume, isr_vector_req, lf_osc_keep, hf_osc_keep;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    slp_wake_ctrl #(.N_IRQ(N_IRQ)) uut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .pin_rst(pin_rst), .brownout_rst(brownout_rst), .poweron_rst(poweron_rst),
        .wdt_expired(wdt_expired), .wdt_sleep_en(wdt_sleep_en),
        .irq_flag(irq_flag), .irq_en(irq_en), .irq_global_en(irq_global_en),
        .post_sleep_done(post_sleep_done),
        .hf_sel_wavegen(hf_sel_wavegen), .hf_sel_nco(hf_sel_nco),
        .cpu_clk_en(cpu_clk_en), .wdt_clear(wdt_clear), .wdt_run(wdt_run),
        .pd_flag(pd_flag), .to_flag(to_flag), .reset_req(reset_req),
        .resume(resume), .isr_vector_req(isr_vector_req),
        .lf_osc_keep(lf_osc_keep), .hf_osc_keep(hf_osc_keep)
    );

    task automatic tick();
        @(posedge clk);
        #1ns;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sleep_req = 0; pin_rst = 0; brownout_rst = 0; poweron_rst = 0;
        wdt_expired = 0; irq_flag = '0; irq_en = '0; irq_global_en = 0;
        post_sleep_done = 0;
    endtask

    task automatic enter_sleep();
        sleep_req = 1;
        tick();
        sleep_req = 0;
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) tick();
        rst_n = 1;
        tick();
        chk("R1 cpu_clk_en", cpu_clk_en, 1'b1);
        chk("R1 pd_flag", pd_flag, 1'b1);
        chk("R1 to_flag", to_flag, 1'b1);
        chk("R1 wdt_clear", wdt_clear, 1'b0);
        chk("R1 reset_req", reset_req, 1'b0);
        chk("R1 resume", resume, 1'b0);
        chk("R1 isr_vector_req", isr_vector_req, 1'b0);

        // Vector table: sleep, apply one wake pattern, check the results
        for (int i = 0; i < NV; i++) begin
            idle_inputs();
            wdt_sleep_en = VECS[i].wse;
            enter_sleep();
            chk("R2 clk gated", cpu_clk_en, 1'b0);
            chk("R2 wdt_clear on entry", wdt_clear, 1'b1);
            chk("R2 pd cleared", pd_flag, 1'b0);
            chk("R2 to set", to_flag, 1'b1);

            {pin_rst, brownout_rst, poweron_rst} = VECS[i].rsrc;
            wdt_expired   = VECS[i].wdt;
            irq_flag      = VECS[i].flg;
            irq_en        = VECS[i].en;
            irq_global_en = VECS[i].gie;
            tick();
            chk("R4 R5 R6 awake", cpu_clk_en, VECS[i].e_awake);
            chk("R4 R5 R6 wdt_clear on wake", wdt_clear, VECS[i].e_awake);
            chk("R4 R7 resume", resume, VECS[i].e_res);
            chk("R6 R7 reset_req", reset_req, VECS[i].e_rst);
            chk("R5 to_flag", to_flag, !(VECS[i].wdt && VECS[i].wse));
            idle_inputs();

            post_sleep_done = 1;
            tick();
            post_sleep_done = 0;
            chk("R7 R8 isr_vector_req", isr_vector_req, VECS[i].e_vec);

            if (!VECS[i].e_awake) begin
                irq_flag = 4'b0001; irq_en = 4'b0001;
                tick();
                idle_inputs();
            end
            tick();
        end

        // R3: oscillator keep-alive and watchdog run
        idle_inputs();
        wdt_sleep_en = 0; hf_sel_nco = 1;
        #1ns;
        chk("R3 hf keep off while running", hf_osc_keep, 1'b0);
        chk("R3 wdt_run while running", wdt_run, 1'b1);
        enter_sleep();
        chk("R3 lf keep", lf_osc_keep, 1'b1);
        chk("R3 hf keep nco", hf_osc_keep, 1'b1);
        chk("R3 wdt_run off", wdt_run, 1'b0);
        wdt_sleep_en = 1;
        #1ns;
        chk("R3 wdt_run on", wdt_run, 1'b1);
        hf_sel_nco = 0; hf_sel_wavegen = 1;
        #1ns;
        chk("R3 hf keep wavegen", hf_osc_keep, 1'b1);
        hf_sel_wavegen = 0;
        #1ns;
        chk("R3 hf keep none", hf_osc_keep, 1'b0);
        irq_flag = 4'b0010; irq_en = 4'b0010;
        tick();
        idle_inputs();
        wdt_sleep_en = 0;
        tick();

        // R9: watchdog timeout while running, held two cycles
        wdt_expired = 1;
        tick();
        chk("R9 reset_req", reset_req, 1'b1);
        chk("R9 to cleared", to_flag, 1'b0);
        tick();
        chk("R9 single pulse", reset_req, 1'b0);
        idle_inputs();
        tick();

        // R10: sleep request with reset source in same cycle
        brownout_rst = 1; sleep_req = 1;
        tick();
        chk("R10 stays running", cpu_clk_en, 1'b1);
        chk("R10 no wdt_clear", wdt_clear, 1'b0);
        chk("R9 reset_req brown-out", reset_req, 1'b1);
        idle_inputs();
        tick();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule